// File: doc/BRIEF.md
# Frequency-Guard Watchdog

This block protects a system against a hang that follows a bad clock frequency setting. Software arms it by writing its enable bit to 1. From then on it counts down once per 250 ms strobe, starting from a programmed depth. If software does not re-arm it in time, the count runs out. The block then does three things. It drives an open-drain reset line low for a fixed number of strobes. It clears the step-less frequency programming mode. It hands a fresh frequency-select code to the frequency logic.

The fresh code comes from one of two places, chosen by a select input: a software-defined safe code, or the code latched from the strap pins at power-up. While the watchdog runs, the depth readback shows the live count. A sticky flag records that a timeout has happened. Generating the clocks themselves is the job of other logic.

Top module: `clk_wdog_guard`

## Requirements
- R1: After reset the block is in this state: `wd_running`=0, `wd_expired`=0, `rst_pull_low`=0, `fsel_load`=0, `stepless_clr`=0 and `fsel_code`=0.
- R2: A cycle with `arm_we`=1 and `arm_wdata`=1 sets `wd_running` to 1 in the next cycle. A cycle with `arm_we`=1 and `arm_wdata`=0 clears `wd_running` without causing a timeout.
- R3: While running, each `tick` cycle lowers the count by one. `cnt_view` shows the live count while running and shows `depth_in` while not running.
- R4: A tick that arrives while the count is 1 or 0 is the timeout tick, so a depth D≥1 expires on the D-th tick. In the next cycle `wd_running` is 0 and `wd_expired` is 1.
- R5: `wd_expired` stays 1 until the next write of 1 to the enable bit, which clears it.
- R6: `rst_pull_low` rises in the cycle after the timeout tick. It falls in the cycle after the PULSE_TICKS-th tick that follows the timeout. Each tick lasts 250 ms, and PULSE_TICKS defaults to 1.
- R7: `stepless_clr` is a one-cycle pulse in the cycle after the timeout tick.
- R8: `fsel_load` pulses for one cycle together with `stepless_clr`. At that point `fsel_code` takes `safe_code` if `safe_sel`=1, or `strap_code` if `safe_sel`=0, both sampled at the timeout tick. `fsel_code` then holds that value.
- R9: Writing 1 to the enable bit while running reloads the count from `depth_in`. This write takes priority over a tick in the same cycle.
- R10: A depth of 0 times out on the first tick after arming.
- R11: Ticks have no effect while the watchdog is not running: no count change, no pulses and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe, once per 250 ms |
| arm_we | input | 1 | Write strobe for the enable bit |
| arm_wdata | input | 1 | Value written to the enable bit |
| depth_in | input | DEPTH_W | Programmed timeout depth, in ticks |
| safe_code | input | CODE_W | Software safe frequency-select code |
| safe_sel | input | 1 | 1 selects `safe_code` on timeout, 0 selects `strap_code` |
| strap_code | input | CODE_W | Frequency code latched from the straps |
| rst_pull_low | output | 1 | Open-drain reset enable; 1 pulls the reset line low |
| cnt_view | output | DEPTH_W | Live count while running, otherwise `depth_in` |
| wd_running | output | 1 | Enable-bit readback |
| wd_expired | output | 1 | Sticky timeout flag |
| fsel_code | output | CODE_W | Frequency-select code restored on timeout |
| fsel_load | output | 1 | One-cycle strobe that writes `fsel_code` |
| stepless_clr | output | 1 | One-cycle strobe that clears step-less mode |

## Verification
The bench keeps the default 7-bit depth and 5-bit code widths. It sets PULSE_TICKS to 3, so the reset pulse must outlast ticks that are not timeout ticks. That setting also exposes any off-by-one in the pulse release. Ticks are spaced a few cycles apart, which lets the bench reach the default 2.0 s depth, a short depth, depth 0, a service kick and a tick that coincides with an enable write. Each of these runs in well under a thousand cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic {
        ARM_STOP = 1'b0,
        ARM_GO   = 1'b1
    } arm_cmd_e;

    // The count is about to run out when a tick finds it at one or zero.
    function automatic logic wdt_last_unit(input logic [31:0] cnt);
        return cnt <= 32'd1;
    endfunction
endpackage

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int DEPTH_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               arm_we,
    input  logic               arm_wdata,
    input  logic [DEPTH_W-1:0] depth_in,
    output logic               running,
    output logic               expired,
    output logic [DEPTH_W-1:0] count,
    output logic               expire_now,
    output logic               stepless_clr
);
    import wdt_pkg::*;

    typedef struct packed {
        logic               run;
        logic               flag;
        logic [DEPTH_W-1:0] cnt;
        logic               clr;
    } cd_state_t;

    cd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.clr   = 1'b0;
        expire_now = 1'b0;
        if (arm_we) begin
            if (arm_wdata == ARM_GO) begin
                st_d.run  = 1'b1;
                st_d.cnt  = depth_in;
                st_d.flag = 1'b0;
            end else begin
                st_d.run = 1'b0;
            end
        end else if (st_q.run && tick) begin
            if (wdt_last_unit(32'(st_q.cnt))) begin
                expire_now = 1'b1;
                st_d.run   = 1'b0;
                st_d.cnt   = '0;
                st_d.flag  = 1'b1;
                st_d.clr   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running      = st_q.run;
    assign expired      = st_q.flag;
    assign count        = st_q.cnt;
    assign stepless_clr = st_q.clr;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int PULSE_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    output logic pull_low
);
    localparam int PW_W = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic [PW_W-1:0] left;
    } pl_state_t;

    pl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start)                         st_d.left = PW_W'(PULSE_TICKS);
        else if (tick && st_q.left != '0)  st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pull_low = (st_q.left != '0);
endmodule

// File: rtl/wdt_recover.sv
module wdt_recover #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              safe_sel,
    input  logic [CODE_W-1:0] safe_code,
    input  logic [CODE_W-1:0] strap_code,
    output logic              fsel_load,
    output logic [CODE_W-1:0] fsel_code
);
    typedef struct packed {
        logic              load;
        logic [CODE_W-1:0] code;
    } rc_state_t;

    rc_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.load = start;
        if (start) st_d.code = safe_sel ? safe_code : strap_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fsel_load = st_q.load;
    assign fsel_code = st_q.code;
endmodule

// File: rtl/clk_wdog_guard.sv
module clk_wdog_guard #(
    parameter int DEPTH_W     = 7,
    parameter int CODE_W      = 5,
    parameter int PULSE_TICKS = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               arm_we,
    input  logic               arm_wdata,
    input  logic [DEPTH_W-1:0] depth_in,
    input  logic [CODE_W-1:0]  safe_code,
    input  logic               safe_sel,
    input  logic [CODE_W-1:0]  strap_code,
    output logic               rst_pull_low,
    output logic [DEPTH_W-1:0] cnt_view,
    output logic               wd_running,
    output logic               wd_expired,
    output logic [CODE_W-1:0]  fsel_code,
    output logic               fsel_load,
    output logic               stepless_clr
);
    logic [DEPTH_W-1:0] live_cnt;
    logic               fire;

    wdt_countdown #(.DEPTH_W(DEPTH_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .arm_we(arm_we), .arm_wdata(arm_wdata), .depth_in(depth_in),
        .running(wd_running), .expired(wd_expired), .count(live_cnt),
        .expire_now(fire), .stepless_clr(stepless_clr)
    );

    wdt_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(fire),
        .pull_low(rst_pull_low)
    );

    wdt_recover #(.CODE_W(CODE_W)) u_rec (
        .clk(clk), .rst_n(rst_n), .start(fire),
        .safe_sel(safe_sel), .safe_code(safe_code), .strap_code(strap_code),
        .fsel_load(fsel_load), .fsel_code(fsel_code)
    );

    assign cnt_view = wd_running ? live_cnt : depth_in;
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
    parameter int DEPTH_W = 7,
    parameter int CODE_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               arm_we,
    input logic               arm_wdata,
    input logic [DEPTH_W-1:0] depth_in,
    input logic [CODE_W-1:0]  safe_code,
    input logic               safe_sel,
    input logic [CODE_W-1:0]  strap_code,
    input logic               rst_pull_low,
    input logic [DEPTH_W-1:0] cnt_view,
    input logic               wd_running,
    input logic               wd_expired,
    input logic [CODE_W-1:0]  fsel_code,
    input logic               fsel_load,
    input logic               stepless_clr
);
    a_r2_arm_starts: assert property (@(posedge clk) disable iff (!rst_n)
        arm_we && arm_wdata |=> wd_running);
    a_r2_disarm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        arm_we && !arm_wdata |=> !wd_running && !stepless_clr);
    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        wd_running && tick && !arm_we && cnt_view > 1
        |=> wd_running && cnt_view == DEPTH_W'($past(cnt_view) - 1'b1));
    a_r3_idle_view: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_running |-> cnt_view == depth_in);
    a_r4_expire: assert property (@(posedge clk) disable iff (!rst_n)
        wd_running && tick && !arm_we && cnt_view <= 1 |=> !wd_running && wd_expired);
    a_r5_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm_we && arm_wdata |=> !wd_expired);
    a_r6_pull_starts: assert property (@(posedge clk) disable iff (!rst_n)
        wd_running && tick && !arm_we && cnt_view <= 1 |=> rst_pull_low);
    a_r7_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stepless_clr |=> !stepless_clr);
    a_r8_load_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stepless_clr |-> fsel_load);
    a_r8_code_source: assert property (@(posedge clk) disable iff (!rst_n)
        fsel_load |-> fsel_code == $past(safe_sel ? safe_code : strap_code));
    a_r9_kick_reload: assert property (@(posedge clk) disable iff (!rst_n)
        wd_running && arm_we && arm_wdata |=> cnt_view == $past(depth_in));
    a_r11_idle_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_running && !arm_we |=> !stepless_clr && !fsel_load);
endmodule

bind clk_wdog_guard wdt_guard_chk #(.DEPTH_W(DEPTH_W), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm_we(arm_we), .arm_wdata(arm_wdata),
    .depth_in(depth_in), .safe_code(safe_code), .safe_sel(safe_sel),
    .strap_code(strap_code), .rst_pull_low(rst_pull_low), .cnt_view(cnt_view),
    .wd_running(wd_running), .wd_expired(wd_expired), .fsel_code(fsel_code),
    .fsel_load(fsel_load), .stepless_clr(stepless_clr)
);

// File: tb/test_clk_wdog_guard.sv
`timescale 1ns/1ps
module test_clk_wdog_guard;
    localparam int DW = 7;
    localparam int CW = 5;
    localparam int PT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, arm_we = 1'b0, arm_wdata = 1'b0, safe_sel = 1'b0;
    logic [DW-1:0] depth_in = 7'd8;
    logic [CW-1:0] safe_code = 5'h13, strap_code = 5'h02;
    logic rst_pull_low, wd_running, wd_expired, fsel_load, stepless_clr;
    logic [DW-1:0] cnt_view;
    logic [CW-1:0] fsel_code;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    clk_wdog_guard #(.DEPTH_W(DW), .CODE_W(CW), .PULSE_TICKS(PT)) i_clk_wdog_guard (
        .clk(clk), .rst_n(rst_n), .tick(tick), .arm_we(arm_we), .arm_wdata(arm_wdata),
        .depth_in(depth_in), .safe_code(safe_code), .safe_sel(safe_sel),
        .strap_code(strap_code), .rst_pull_low(rst_pull_low), .cnt_view(cnt_view),
        .wd_running(wd_running), .wd_expired(wd_expired), .fsel_code(fsel_code),
        .fsel_load(fsel_load), .stepless_clr(stepless_clr)
    );

    // behavioural reference
    int m_run, m_cnt, m_to, m_pul, m_fl, m_sc, m_code;
    bit m_fire;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_to = 0; m_pul = 0; m_fl = 0; m_sc = 0; m_code = 0;
        end else begin
            m_fire = 0; m_fl = 0; m_sc = 0;
            if (arm_we) begin
                if (arm_wdata) begin m_run = 1; m_cnt = int'(depth_in); m_to = 0; end
                else m_run = 0;
            end else if (m_run == 1 && tick) begin
                if (m_cnt <= 1) begin
                    m_fire = 1; m_run = 0; m_cnt = 0; m_to = 1; m_fl = 1; m_sc = 1;
                    m_code = safe_sel ? int'(safe_code) : int'(strap_code);
                end else m_cnt = m_cnt - 1;
            end
            if (m_fire) m_pul = PT;
            else if (tick && m_pul > 0) m_pul = m_pul - 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 running", 32'(wd_running), m_run);
        chk("R3 cnt_view", 32'(cnt_view), m_run == 1 ? m_cnt : int'(depth_in));
        chk("R5 expired", 32'(wd_expired), m_to);
        chk("R6 pull_low", 32'(rst_pull_low), m_pul > 0 ? 1 : 0);
        chk("R7 stepless_clr", 32'(stepless_clr), m_sc);
        chk("R8 fsel_load", 32'(fsel_load), m_fl);
        chk("R8 fsel_code", 32'(fsel_code), m_code);
    endtask

    task automatic adv();
        @(negedge clk);
        if (rst_n) compare_all();
    endtask

    task automatic do_tick();
        tick = 1'b1; adv(); tick = 1'b0; adv(); adv();
    endtask

    task automatic arm(input logic v);
        arm_we = 1'b1; arm_wdata = v; adv(); arm_we = 1'b0; adv();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 running", 32'(wd_running), 0);
        chk("R1 expired", 32'(wd_expired), 0);
        chk("R1 pull_low", 32'(rst_pull_low), 0);
        chk("R1 fsel_code", 32'(fsel_code), 0);
        chk("R1 pulses", 32'({fsel_load, stepless_clr}), 0);

        // R11 ticks while idle change nothing
        do_tick(); do_tick();
        chk("R11 idle", 32'({wd_running, wd_expired, rst_pull_low}), 0);

        // R4 default depth 8 expires on eighth tick, strap path (R8)
        depth_in = 7'd8; safe_sel = 1'b0;
        arm(1'b1);
        chk("R2 armed", 32'(wd_running), 1);
        for (int i = 0; i < 7; i++) do_tick();
        chk("R4 still running after 7", 32'(wd_running), 1);
        chk("R3 count at 1", 32'(cnt_view), 1);
        do_tick();
        chk("R4 expired on 8th", 32'(wd_expired), 1);
        chk("R8 strap code", 32'(fsel_code), 32'h02);
        // R6 pulse holds for PT ticks
        do_tick(); do_tick();
        chk("R6 still low", 32'(rst_pull_low), 1);
        do_tick();
        chk("R6 released", 32'(rst_pull_low), 0);

        // R5 re-arm clears flag; R8 safe path with depth 3
        depth_in = 7'd3; safe_sel = 1'b1;
        arm(1'b1);
        chk("R5 flag cleared", 32'(wd_expired), 0);
        do_tick(); do_tick(); do_tick();
        chk("R8 safe code", 32'(fsel_code), 32'h13);

        // R9 kick reloads
        depth_in = 7'd5;
        arm(1'b1);
        do_tick(); do_tick(); do_tick();
        chk("R3 count 2", 32'(cnt_view), 2);
        arm(1'b1);
        chk("R9 reloaded", 32'(cnt_view), 5);
        // R9 arm coincident with tick: arm wins
        tick = 1'b1; arm_we = 1'b1; arm_wdata = 1'b1; adv();
        tick = 1'b0; arm_we = 1'b0; adv();
        chk("R9 arm beats tick", 32'(cnt_view), 5);

        // R2 disarm stops without timeout
        arm(1'b0);
        do_tick(); do_tick(); do_tick(); do_tick(); do_tick(); do_tick();
        chk("R2 disarmed no expiry", 32'({wd_running, wd_expired}), 0);

        // R10 depth zero
        depth_in = 7'd0; strap_code = 5'h1c; safe_sel = 1'b0;
        arm(1'b1);
        do_tick();
        chk("R10 depth0 expired", 32'(wd_expired), 1);
        chk("R10 strap code", 32'(fsel_code), 32'h1c);
        repeat (4) do_tick();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule